// File: doc/BRIEF.md
# UART Boot Download Handshake Engine

This engine runs the device side of a serial boot download. It sits behind an 8-bit byte stream that a separate UART (8 data bits, no parity, one stop bit, 115200 baud) turns into serial traffic. A pulse on `start` makes the engine announce itself with an STX byte. It then collects a three-byte header from the host, accepts or rejects it, and stores the code image that follows into RAM words. At the end it returns a checksum and waits for the host's final verdict.

Code bytes are packed little-endian into 32-bit RAM words, starting at a fixed word address. A header that does not start with SOH is rejected, and the engine starts over with a new STX. A programmable silence limit stops a session that has stalled while the engine is waiting for the host.

Top module: `boot_dl_engine`

## Requirements
- R1: After reset the engine is idle: `tx_valid`, `rx_ready`, `ram_we`, `done` and `error` are all 0.
- R2: A `start` pulse while idle makes the engine offer byte 0x02 (STX) on `tx_data`. While `tx_valid` is high and `tx_ready` is low, the valid flag and the byte stay unchanged.
- R3: The header is three received bytes: SOH (0x01), then the length low byte, then the length high byte. The length counts code bytes. After the third byte the engine sends 0x06 (ACK) if the first byte was 0x01, and 0x15 (NACK) otherwise.
- R4: After a NACK the engine sends STX again and collects a fresh three-byte header.
- R5: Code byte k is written to word address BASE + k/4, in bits [8*(k%4)+7 : 8*(k%4)], with `ram_be` bit k%4 set.
- R6: Full words are written with `ram_be` = 4'hF. A trailing partial word carries enables only for its filled low lanes (4'h1, 4'h3 or 4'h7), and the unused lanes hold zero. Every write has lane 0 enabled.
- R7: Once the last code byte is in, the engine sends one checksum byte. Its value is 0xFF XOR every code byte. A zero-length image therefore gives 0xFF.
- R8: After the checksum, a host reply of 0x06 sets `done` and any other byte sets `error`. The engine returns to idle, and both flags stay held until the next `start`. They are never high together.
- R9: While waiting for a received byte, `timeout_cycles` consecutive cycles with no accepted byte return the engine to idle with `error` set. Each accepted byte restarts the count.
- R10: `tx_valid` and `rx_ready` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a session when idle |
| timeout_cycles | input | TCW | Silence limit in cycles (at least 1) |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | UART accepts the transmit byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Engine accepts a received byte |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_be | output | 4 | RAM byte-lane enables |
| done | output | 1 | Session finished with host ACK |
| error | output | 1 | Session ended by bad final reply or timeout |

## Verification
The bench sends a six-byte image, so the last word is partial. A packer with its lanes wrong would swap bytes or enable lanes that were never filled. A wrong SOH must produce NACK followed by a second STX; an engine that went on to the code phase would write garbage into RAM. A zero-length header checks that the engine goes straight to a 0xFF checksum without any RAM write, and the same session's wrong final reply must raise `error` rather than `done`. Silence in the header phase must end the session, while bytes spaced just under the limit must not. A counter that never resets, or that is off by one, fails one of these two cases.

// File: rtl/boot_dl_pkg.sv
package boot_dl_pkg;
  localparam int LEN_W = 16;
  localparam logic [7:0] BYTE_STX  = 8'h02;
  localparam logic [7:0] BYTE_SOH  = 8'h01;
  localparam logic [7:0] BYTE_ACK  = 8'h06;
  localparam logic [7:0] BYTE_NACK = 8'h15;
  localparam logic [7:0] CSUM_SEED = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STX, ST_HDR, ST_HACK, ST_CODE, ST_CSUM, ST_FACK
  } dl_state_t;

  function automatic logic [7:0] csum_step(input logic [7:0] c, input logic [7:0] b);
    return c ^ b;
  endfunction

  function automatic logic [31:0] lane_insert(input logic [31:0] w, input logic [7:0] b,
                                              input logic [1:0] lane);
    logic [31:0] r;
    r = w;
    r[lane*8 +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/boot_dl_timer.sv
module boot_dl_timer #(
  parameter int TCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           kick,
  input  logic [TCW-1:0] limit,
  output logic           expired
);
  logic [TCW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || kick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign expired = run && !kick && ({1'b0, cnt} + 1'b1 >= {1'b0, limit});

  // R9
  timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt == '0);
endmodule

// File: rtl/boot_dl_packer.sv
module boot_dl_packer import boot_dl_pkg::*; #(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [7:0]    din,
  input  logic          flush,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [31:0]   wdata,
  output logic [3:0]    be
);
  logic [1:0]    lane;
  logic [31:0]   acc;
  logic [3:0]    mask;
  logic [AW-1:0] widx;
  logic [31:0]   merged;
  logic [3:0]    mnext;

  assign merged = lane_insert(acc, din, lane);
  assign mnext  = mask | (4'b0001 << lane);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane <= '0; acc <= '0; mask <= '0; widx <= '0;
      we <= 1'b0; addr <= '0; wdata <= '0; be <= '0;
    end else begin
      we <= 1'b0;
      if (clear) begin
        lane <= '0; acc <= '0; mask <= '0; widx <= '0;
      end else if (push) begin
        if (lane == 2'd3 || flush) begin
          we    <= 1'b1;
          wdata <= merged;
          be    <= mnext;
          addr  <= BASE + widx;
          widx  <= widx + 1'b1;
          acc   <= '0;
          mask  <= '0;
          lane  <= '0;
        end else begin
          acc  <= merged;
          mask <= mnext;
          lane <= lane + 1'b1;
        end
      end
    end
  end

  // R6
  lane0_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (be == 4'h1 || be == 4'h3 || be == 4'h7 || be == 4'hF));
endmodule

// File: rtl/boot_dl_engine.sv
module boot_dl_engine import boot_dl_pkg::*; #(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 'h100,
  parameter int TCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [TCW-1:0] timeout_cycles,
  output logic [7:0]     tx_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  input  logic [7:0]     rx_data,
  input  logic           rx_valid,
  output logic           rx_ready,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [31:0]    ram_wdata,
  output logic [3:0]     ram_be,
  output logic           done,
  output logic           error
);
  dl_state_t        state;
  logic [1:0]       hdr_idx;
  logic             hdr_ok;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] remain;
  logic [7:0]       csum;
  logic             rx_fire, tx_fire, tmo, last_byte, code_push, pack_clear;

  assign rx_ready   = (state == ST_HDR) || (state == ST_CODE) || (state == ST_FACK);
  assign tx_valid   = (state == ST_STX) || (state == ST_HACK) || (state == ST_CSUM);
  assign rx_fire    = rx_valid && rx_ready;
  assign tx_fire    = tx_valid && tx_ready;
  assign last_byte  = (remain == LEN_W'(1));
  assign code_push  = rx_fire && (state == ST_CODE);
  assign pack_clear = tx_fire && (state == ST_HACK);

  always_comb begin
    case (state)
      ST_STX:  tx_data = BYTE_STX;
      ST_HACK: tx_data = hdr_ok ? BYTE_ACK : BYTE_NACK;
      ST_CSUM: tx_data = csum;
      default: tx_data = 8'h00;
    endcase
  end

  boot_dl_timer #(.TCW(TCW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(rx_ready), .kick(rx_fire),
    .limit(timeout_cycles), .expired(tmo)
  );

  boot_dl_packer #(.AW(AW), .BASE(BASE)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(pack_clear), .push(code_push),
    .din(rx_data), .flush(last_byte), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .be(ram_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; hdr_idx <= '0; hdr_ok <= 1'b0; len_q <= '0;
      remain <= '0; csum <= CSUM_SEED; done <= 1'b0; error <= 1'b0;
    end else if (tmo) begin
      state <= ST_IDLE;
      error <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          done <= 1'b0; error <= 1'b0; state <= ST_STX;
        end
        ST_STX: if (tx_fire) begin
          hdr_idx <= '0; hdr_ok <= 1'b0; state <= ST_HDR;
        end
        ST_HDR: if (rx_fire) begin
          hdr_idx <= hdr_idx + 1'b1;
          case (hdr_idx)
            2'd0:    hdr_ok <= (rx_data == BYTE_SOH);
            2'd1:    len_q[7:0] <= rx_data;
            default: begin len_q[15:8] <= rx_data; state <= ST_HACK; end
          endcase
        end
        ST_HACK: if (tx_fire) begin
          csum   <= CSUM_SEED;
          remain <= len_q;
          if (!hdr_ok)            state <= ST_STX;
          else if (len_q == '0)   state <= ST_CSUM;
          else                    state <= ST_CODE;
        end
        ST_CODE: if (rx_fire) begin
          csum   <= csum_step(csum, rx_data);
          remain <= remain - 1'b1;
          if (last_byte) state <= ST_CSUM;
        end
        ST_CSUM: if (tx_fire) state <= ST_FACK;
        ST_FACK: if (rx_fire) begin
          if (rx_data == BYTE_ACK) done <= 1'b1;
          else                     error <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10
  no_dual_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R9
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (!rx_ready && !tx_valid && error));
  // R5
  write_in_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(code_push));
endmodule

// File: tb/boot_dl_engine_test.sv
module boot_dl_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam logic [AW-1:0] BASE = 12'h100;
  localparam int LIMIT = 20;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] timeout_cycles = 16'(LIMIT);
  logic [7:0] tx_data, rx_data = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic ram_we; logic [AW-1:0] ram_addr; logic [31:0] ram_wdata; logic [3:0] ram_be;
  logic done, error;
  int checks = 0, fails = 0, nwrites = 0;
  logic [31:0] wd [0:15];
  logic [3:0]  wb [0:15];
  logic [AW-1:0] wa [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_dl_engine #(.AW(AW), .BASE(BASE), .TCW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .timeout_cycles(timeout_cycles),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_be(ram_be),
    .done(done), .error(error));

  always @(negedge clk) if (rst_n && ram_we && nwrites < 16) begin
    wa[nwrites] = ram_addr; wd[nwrites] = ram_wdata; wb[nwrites] = ram_be;
    nwrites = nwrites + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic expect_tx(input logic [7:0] exp, input string req);
    while (!tx_valid) @(negedge clk);
    check(tx_data == exp, req, tx_data, exp);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    rx_valid = 1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset();
    check(!tx_valid && !rx_ready && !ram_we && !done && !error, "R1",
          {tx_valid, rx_ready, ram_we, done, error}, 0);
  endtask

  task automatic t_normal();
    logic [7:0] img [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'h5A};
    logic [7:0] cs = 8'hFF;
    nwrites = 0;
    pulse_start();
    tx_ready = 0; repeat (3) @(negedge clk);
    check(tx_valid && tx_data == 8'h02, "R2 hold", tx_data, 8'h02);
    expect_tx(8'h02, "R2");
    send_rx(8'h01); send_rx(8'h06); send_rx(8'h00);
    expect_tx(8'h06, "R3 ack");
    foreach (img[i]) begin send_rx(img[i]); cs ^= img[i]; end
    expect_tx(cs, "R7 csum");
    check(nwrites == 2, "R5 count", nwrites, 2);
    check(wa[0] == BASE && wd[0] == 32'h44332211 && wb[0] == 4'hF, "R5 word0", wd[0], 32'h44332211);
    check(wa[1] == BASE + 1 && wd[1] == 32'h00005AA5 && wb[1] == 4'h3, "R6 tail",
          {wb[1], wd[1][27:0]}, {4'h3, 28'h0005AA5});
    send_rx(8'h06); @(negedge clk);
    check(done && !error, "R8 done", {done, error}, 2'b10);
    check(!rx_ready && !tx_valid, "R10 idle", {rx_ready, tx_valid}, 0);
  endtask

  task automatic t_nack();
    nwrites = 0;
    pulse_start();
    check(!done, "R8 cleared", done, 0);
    expect_tx(8'h02, "R2");
    send_rx(8'h7E); send_rx(8'h04); send_rx(8'h00);
    expect_tx(8'h15, "R3 nack");
    expect_tx(8'h02, "R4 restx");
    send_rx(8'h01); send_rx(8'h04); send_rx(8'h00);
    expect_tx(8'h06, "R4 ack");
    send_rx(8'hDE); send_rx(8'hAD); send_rx(8'hBE); send_rx(8'hEF);
    expect_tx(8'hFF ^ 8'hDE ^ 8'hAD ^ 8'hBE ^ 8'hEF, "R7 csum4");
    check(nwrites == 1 && wb[0] == 4'hF && wd[0] == 32'hEFBEADDE, "R6 full", wd[0], 32'hEFBEADDE);
    send_rx(8'h06); @(negedge clk);
    check(done, "R8 done2", done, 1);
  endtask

  task automatic t_zero_len();
    nwrites = 0;
    pulse_start();
    expect_tx(8'h02, "R2");
    send_rx(8'h01); send_rx(8'h00); send_rx(8'h00);
    expect_tx(8'h06, "R3 ack0");
    expect_tx(8'hFF, "R7 zero");
    send_rx(8'h15); @(negedge clk);
    check(error && !done, "R8 bad ack", {done, error}, 2'b01);
    check(nwrites == 0, "R5 nowrite", nwrites, 0);
  endtask

  task automatic t_timeout();
    pulse_start();
    expect_tx(8'h02, "R2");
    repeat (LIMIT - 4) @(negedge clk);
    send_rx(8'h01);
    repeat (LIMIT - 4) @(negedge clk);
    send_rx(8'h03);
    check(rx_ready && !error, "R9 keepalive", {rx_ready, error}, 2'b10);
    repeat (LIMIT + 3) @(negedge clk);
    check(error && !rx_ready && !tx_valid, "R9 expire", {error, rx_ready, tx_valid}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_normal();
    t_nack();
    t_zero_len();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule